// File: doc/BRIEF.md
# Debug Exit Controller

This block governs how a processor core leaves its halted debug state. While the core is halted, a debug host writes words into an injection register. Each write carries two qualifier bits: `go` and `ex`. A write with `go` low only stores the word. A write with `go` high hands the stored word to the core over a valid/ready handshake. If `ex` is also set, the core is released from debug once it has accepted that word.

The block records the program fetch address at the moment of halting. On an exit that restored the original pipeline, it pulses a program-address-bus reload so that fetching resumes at the interrupted point.

An exit that follows an injected jump needs no such reload. The block detects this because an issue with `go` set and `ex` clear was accepted earlier in the same debug session.

A hardware reset takes the core out of debug. The exception is when the scan port's instruction register is decoding a debug request; in that case the core stays halted with a cleared injection register.

Top module: `dbg_exit_ctrl`

## Requirements
- R1: While `rst_n` is low, at the clock edge: `debug_active` takes the value of `dbg_req_decoded`, the injection register (seen on `iss_data`) clears to zero, and `iss_valid`, `overrun` and `cmd_ready` clear.
- R2: An `enter_debug` pulse while not in debug sets `debug_active` one cycle later and captures `fetch_addr` onto `pab_addr`. An `enter_debug` pulse while already in debug changes neither.
- R3: An accepted load with `go`=0 writes `ld_data` into the injection register (visible on `iss_data` the next cycle) and raises no `iss_valid`. The core stays in debug, and `ex` has no effect.
- R4: An accepted load with `go`=1, `ex`=0 raises `iss_valid` the next cycle carrying the new word. After the core accepts it (`iss_valid` and `iss_ready` high at an edge), `debug_active` stays high and `cmd_ready` goes high.
- R5: An accepted load with `go`=1, `ex`=1 raises `iss_valid` with the word. After acceptance, `debug_active` is low from the next cycle.
- R6: An exit where no `go`=1, `ex`=0 issue was accepted during the session pulses `pab_restore` high for exactly one cycle, coincident with `debug_active` falling. Meanwhile `pab_addr` shows the captured fetch address.
- R7: An exit that follows an accepted `go`=1, `ex`=0 issue in the same session gives no `pab_restore` pulse.
- R8: A load arriving while `iss_valid` is high is ignored, leaving the injection register unchanged, and sets `overrun`. `overrun` stays high until reset.
- R9: While `iss_valid` is high and `iss_ready` low, `iss_valid` stays high and `iss_data` stays stable.
- R10: A load while `debug_active` is low is ignored: nothing is stored and nothing is issued.
- R11: `cmd_ready` clears on the cycle after the next accepted load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| dbg_req_decoded | input | 1 | Scan-port instruction register is decoding a debug request |
| enter_debug | input | 1 | Pulse: core has halted into debug |
| fetch_addr | input | AW (16) | Fetch address at the halt |
| ld_valid | input | 1 | One-cycle load strobe for the injection register |
| ld_data | input | DW (16) | Word to load |
| ld_go | input | 1 | Issue qualifier |
| ld_ex | input | 1 | Exit qualifier |
| iss_valid | output | 1 | Word offered to the core |
| iss_ready | input | 1 | Core accepts the offered word |
| iss_data | output | DW (16) | Injection register contents |
| debug_active | output | 1 | Core is held in debug |
| cmd_ready | output | 1 | Non-exiting issue accepted; ready for next command |
| overrun | output | 1 | Sticky: a load arrived while an issue was pending |
| pab_restore | output | 1 | One-cycle program-address-bus reload pulse |
| pab_addr | output | AW (16) | Saved fetch address for the reload |

## Verification
The bench builds the block with its default 16-bit data and 16-bit address widths. It uses distinct nonzero word and address patterns, so a swapped, stale or cleared value shows on `iss_data` and `pab_addr`. These widths bring both exit sequences within reach: the doubled restore write and the jump/target/no-op triple. They also reach core stalls of several cycles against a pending issue, and a reset taken with and without the debug request decoded.

// File: rtl/dbg_exit_pkg.sv
package dbg_exit_pkg;

    localparam int unsigned DATA_W = 16;
    localparam int unsigned ADDR_W = 16;

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              valid;
        logic              ex_pend;
        logic              ovr;
    } inj_state_t;

    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] saved;
        logic              flow_chg;
        logic              cmd_rdy;
        logic              pab_pulse;
    } sess_state_t;

endpackage

// File: rtl/dbg_inject_reg.sv
module dbg_inject_reg
    import dbg_exit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              ld_valid,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              ld_go,
    input  logic              ld_ex,
    input  logic              iss_ready,
    output logic              iss_valid,
    output logic [DATA_W-1:0] iss_data,
    output logic              overrun,
    output logic              ld_accept,
    output logic              fire,
    output logic              fire_ex
);

    inj_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        ld_accept = ld_valid && active && !st_q.valid;
        fire      = st_q.valid && iss_ready;
        fire_ex   = st_q.ex_pend;

        if (fire) begin
            st_d.valid   = 1'b0;
            st_d.ex_pend = 1'b0;
        end

        if (ld_valid && active && st_q.valid) begin
            st_d.ovr = 1'b1;
        end else if (ld_accept) begin
            st_d.word = ld_data;
            if (ld_go) begin
                st_d.valid   = 1'b1;
                st_d.ex_pend = ld_ex;
            end
        end

        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign iss_valid = st_q.valid;
    assign iss_data  = st_q.word;
    assign overrun   = st_q.ovr;

    // R3: a store-only load never produces an issue
    a_r3_store_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_accept && !ld_go) |=> !iss_valid);

    // R9: pending issue is held with stable data until taken
    a_r9_hold_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_data)));

    // R8: the overrun flag is sticky
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R8: a colliding load leaves the register untouched
    a_r8_ignore_word: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && iss_valid && !iss_ready) |=> $stable(iss_data));

endmodule

// File: rtl/dbg_session.sv
module dbg_session
    import dbg_exit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_req_decoded,
    input  logic              enter_debug,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              ld_accept,
    input  logic              fire,
    input  logic              fire_ex,
    output logic              active,
    output logic              cmd_ready,
    output logic              pab_restore,
    output logic [ADDR_W-1:0] pab_addr
);

    sess_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.pab_pulse = 1'b0;

        if (!st_q.active && enter_debug) begin
            st_d.active   = 1'b1;
            st_d.saved    = fetch_addr;
            st_d.flow_chg = 1'b0;
            st_d.cmd_rdy  = 1'b0;
        end

        if (st_q.active && ld_accept) begin
            st_d.cmd_rdy = 1'b0;
        end

        if (st_q.active && fire) begin
            if (fire_ex) begin
                st_d.active    = 1'b0;
                st_d.pab_pulse = !st_q.flow_chg;
            end else begin
                st_d.flow_chg = 1'b1;
                st_d.cmd_rdy  = 1'b1;
            end
        end

        if (!rst_n) begin
            st_d        = '0;
            st_d.active = dbg_req_decoded;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign active      = st_q.active;
    assign cmd_ready   = st_q.cmd_rdy;
    assign pab_restore = st_q.pab_pulse;
    assign pab_addr    = st_q.saved;

    // R4: a non-exiting issue keeps the core halted
    a_r4_stay_halted: assert property (@(posedge clk) disable iff (!rst_n)
        (active && fire && !fire_ex) |=> (active && cmd_ready));

    // R5: an exiting issue releases the core
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (active && fire && fire_ex) |=> !active);

    // R6: reload pulse only together with leaving debug, and only one cycle long
    a_r6_pulse_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
        pab_restore |-> (!active && $past(active)));
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pab_restore |=> !pab_restore);

    // R2: saved address frozen while halted
    a_r2_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> $stable(pab_addr));

endmodule

// File: rtl/dbg_exit_ctrl.sv
module dbg_exit_ctrl
    import dbg_exit_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dbg_req_decoded,
    input  logic          enter_debug,
    input  logic [AW-1:0] fetch_addr,
    input  logic          ld_valid,
    input  logic [DW-1:0] ld_data,
    input  logic          ld_go,
    input  logic          ld_ex,
    output logic          iss_valid,
    input  logic          iss_ready,
    output logic [DW-1:0] iss_data,
    output logic          debug_active,
    output logic          cmd_ready,
    output logic          overrun,
    output logic          pab_restore,
    output logic [AW-1:0] pab_addr
);

    logic ld_accept;
    logic fire;
    logic fire_ex;

    dbg_inject_reg u_inject (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (debug_active),
        .ld_valid  (ld_valid),
        .ld_data   (ld_data),
        .ld_go     (ld_go),
        .ld_ex     (ld_ex),
        .iss_ready (iss_ready),
        .iss_valid (iss_valid),
        .iss_data  (iss_data),
        .overrun   (overrun),
        .ld_accept (ld_accept),
        .fire      (fire),
        .fire_ex   (fire_ex)
    );

    dbg_session u_session (
        .clk             (clk),
        .rst_n           (rst_n),
        .dbg_req_decoded (dbg_req_decoded),
        .enter_debug     (enter_debug),
        .fetch_addr      (fetch_addr),
        .ld_accept       (ld_accept),
        .fire            (fire),
        .fire_ex         (fire_ex),
        .active          (debug_active),
        .cmd_ready       (cmd_ready),
        .pab_restore     (pab_restore),
        .pab_addr        (pab_addr)
    );

    // R10: nothing is issued while the core runs
    a_r10_idle_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
        !debug_active |=> !iss_valid);

endmodule

// File: tb/dbg_exit_ctrl_tb_top.sv
module dbg_exit_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_req_decoded = 1'b0;
    logic        enter_debug = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        ld_valid = 1'b0;
    logic [15:0] ld_data = '0;
    logic        ld_go = 1'b0;
    logic        ld_ex = 1'b0;
    logic        iss_valid;
    logic        iss_ready = 1'b0;
    logic [15:0] iss_data;
    logic        debug_active;
    logic        cmd_ready;
    logic        overrun;
    logic        pab_restore;
    logic [15:0] pab_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbg_exit_ctrl dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .dbg_req_decoded (dbg_req_decoded),
        .enter_debug     (enter_debug),
        .fetch_addr      (fetch_addr),
        .ld_valid        (ld_valid),
        .ld_data         (ld_data),
        .ld_go           (ld_go),
        .ld_ex           (ld_ex),
        .iss_valid       (iss_valid),
        .iss_ready       (iss_ready),
        .iss_data        (iss_data),
        .debug_active    (debug_active),
        .cmd_ready       (cmd_ready),
        .overrun         (overrun),
        .pab_restore     (pab_restore),
        .pab_addr        (pab_addr)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic req);
        @(negedge clk);
        rst_n = 1'b0;
        dbg_req_decoded = req;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        dbg_req_decoded = 1'b0;
    endtask

    task automatic load(input logic [15:0] w, input logic go, input logic ex);
        @(negedge clk);
        ld_valid = 1'b1; ld_data = w; ld_go = go; ld_ex = ex;
        @(negedge clk);
        ld_valid = 1'b0; ld_go = 1'b0; ld_ex = 1'b0;
    endtask

    task automatic accept();
        iss_ready = 1'b1;
        @(negedge clk);
        iss_ready = 1'b0;
    endtask

    task automatic halt(input logic [15:0] a);
        @(negedge clk);
        enter_debug = 1'b1; fetch_addr = a;
        @(negedge clk);
        enter_debug = 1'b0; fetch_addr = 16'h0;
    endtask

    task automatic t_reset_plain();
        do_reset(1'b0);
        check("R1", "debug_active", int'(debug_active), 0);
        check("R1", "iss_valid", int'(iss_valid), 0);
        check("R1", "overrun", int'(overrun), 0);
        check("R1", "iss_data", int'(iss_data), 0);
        check("R1", "cmd_ready", int'(cmd_ready), 0);
    endtask

    task automatic t_load_outside();
        load(16'h1234, 1'b1, 1'b1);
        check("R10", "iss_valid", int'(iss_valid), 0);
        check("R10", "iss_data", int'(iss_data), 0);
        @(negedge clk);
        check("R10", "iss_valid later", int'(iss_valid), 0);
    endtask

    task automatic t_enter();
        halt(16'h0A50);
        check("R2", "debug_active", int'(debug_active), 1);
        check("R2", "pab_addr", int'(pab_addr), 16'h0A50);
        halt(16'h7777);
        check("R2", "pab_addr re-enter", int'(pab_addr), 16'h0A50);
    endtask

    task automatic t_store();
        load(16'hBEEF, 1'b0, 1'b1);
        check("R3", "iss_data", int'(iss_data), 16'hBEEF);
        check("R3", "iss_valid", int'(iss_valid), 0);
        check("R3", "debug_active", int'(debug_active), 1);
    endtask

    task automatic t_restore_exit();
        load(16'hBEEF, 1'b1, 1'b1);
        check("R5", "iss_valid", int'(iss_valid), 1);
        check("R5", "iss_data", int'(iss_data), 16'hBEEF);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R9", "iss_valid stall", int'(iss_valid), 1);
            check("R9", "iss_data stall", int'(iss_data), 16'hBEEF);
        end
        check("R5", "still halted", int'(debug_active), 1);
        accept();
        check("R5", "debug_active after", int'(debug_active), 0);
        check("R5", "iss_valid after", int'(iss_valid), 0);
        check("R6", "pab_restore", int'(pab_restore), 1);
        check("R6", "pab_addr", int'(pab_addr), 16'h0A50);
        @(negedge clk);
        check("R6", "pab_restore one cycle", int'(pab_restore), 0);
    endtask

    task automatic t_jump_exit();
        halt(16'h0123);
        load(16'h0D00, 1'b0, 1'b0);
        check("R3", "jump stored", int'(iss_data), 16'h0D00);
        load(16'h2200, 1'b1, 1'b0);
        check("R4", "iss_valid", int'(iss_valid), 1);
        check("R4", "iss_data", int'(iss_data), 16'h2200);
        accept();
        check("R4", "debug_active", int'(debug_active), 1);
        check("R4", "cmd_ready", int'(cmd_ready), 1);
        check("R4", "iss_valid", int'(iss_valid), 0);
        load(16'h0000, 1'b1, 1'b1);
        check("R11", "cmd_ready cleared", int'(cmd_ready), 0);
        accept();
        check("R5", "released", int'(debug_active), 0);
        check("R7", "no pab_restore", int'(pab_restore), 0);
        @(negedge clk);
        check("R7", "no pab_restore later", int'(pab_restore), 0);
    endtask

    task automatic t_overrun();
        halt(16'h0456);
        load(16'h1111, 1'b1, 1'b0);
        check("R8", "overrun before", int'(overrun), 0);
        load(16'h2222, 1'b0, 1'b0);
        check("R8", "iss_data kept", int'(iss_data), 16'h1111);
        check("R8", "overrun set", int'(overrun), 1);
        accept();
        @(negedge clk);
        @(negedge clk);
        check("R8", "overrun sticky", int'(overrun), 1);
    endtask

    task automatic t_reset_in_debug();
        do_reset(1'b1);
        check("R1", "debug_active held", int'(debug_active), 1);
        check("R1", "iss_data cleared", int'(iss_data), 0);
        check("R8", "overrun cleared", int'(overrun), 0);
    endtask

    initial begin
        t_reset_plain();
        t_load_outside();
        t_enter();
        t_store();
        t_restore_exit();
        t_jump_exit();
        t_overrun();
        t_reset_in_debug();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule